// File: doc/BRIEF.md
# ADC Result Register Read Interlock

This block sits between an analog-to-digital converter core and an 8-bit processor bus. Each time the converter signals a finished conversion, the block captures the result into a pair of byte-wide result registers, one high and one low. It also holds a configuration register whose fields drive the converter's clock and mode selection.

In 10-bit resolution, a 10-bit value has to be read as two bytes. The block keeps those two bytes consistent. Reading the high byte freezes the result registers. Reading the low byte releases them. Any conversion that completes while the registers are frozen is thrown away and is not queued. In 8-bit resolution the whole result fits in the low byte, so there is no freezing at all.

Bus reads are combinational from the address. A read takes effect on the lock at the clock edge where the read strobe is high. The address map is: 0 = result high, 1 = result low, 2 = configuration, 3 = reads zero.

Top module: `adc_result_lock`

## Requirements
- R1: When a conversion-complete strobe arrives and the registers are not frozen, the result registers hold the new value from the next cycle on.
- R2: In 10-bit mode, a bus read of address 0 (high byte) freezes the result registers. A conversion that completes while they are frozen is discarded, and the registers keep the earlier value.
- R3: A bus read of address 1 (low byte) releases the freeze. The next conversion then loads normally.
- R4: If a high-byte read and a conversion completion fall in the same cycle, the read wins. The read returns the old value, and the new conversion is dropped.
- R5: Resolution mode is configuration bits 3:2. The value 01 selects 10-bit mode. The values 00, 10 and 11 all select 8-bit mode. In 8-bit mode:
  - a high-byte read never freezes the registers;
  - address 0 reads as zero;
  - address 1 returns result bits 7:0 of the latest conversion.
- R6: In 10-bit mode, address 0 returns result bits 9:8 in data bits 1:0, with data bits 7:2 at zero. Address 1 returns result bits 7:0.
- R7: The configuration register at address 2 is written by a bus write and reads back as written. Its fields drive the outputs as follows:
  - bit 7: low-power select;
  - bits 6:5: clock divide;
  - bit 4: input clock select;
  - bits 3:2: mode;
  - bit 1: long sample;
  - bit 0: asynchronous clock enable.
- R8: Reset clears the configuration register, both result bytes and the freeze.
- R9: Bus writes to addresses 0 and 1 change nothing. A low-byte read when no freeze is set has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | Conversion-complete strobe, one cycle |
| conv_data | input | 10 | Converter result |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cfg_lowpwr | output | 1 | Low-power select |
| cfg_clkdiv | output | 2 | Clock divide select |
| cfg_clksel | output | 1 | Input clock select |
| cfg_mode | output | 2 | Resolution mode |
| cfg_longsmp | output | 1 | Long sample select |
| cfg_asyncen | output | 1 | Asynchronous clock enable |

## Verification
The capture path is swept over every 10-bit code in 10-bit mode and every 8-bit code in 8-bit mode. This separates errors in bit placement from errors in masking.

The freeze is tested with several orderings:
- high read, then conversion, then low read;
- a high read and a conversion in the same cycle;
- a low read with no freeze set;
- the same orderings under each 8-bit-class mode code.

Together these distinguish a lock that never sets, a lock that never clears, a queued result, and a lock that wrongly appears in 8-bit mode.

The configuration register is swept over all 256 values, each compared against the readback and the individual field outputs.

// File: rtl/adc_result_lock.sv
module adc_result_lock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_done,
  input  logic [9:0] conv_data,
  input  logic [1:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cfg_lowpwr,
  output logic [1:0] cfg_clkdiv,
  output logic       cfg_clksel,
  output logic [1:0] cfg_mode,
  output logic       cfg_longsmp,
  output logic       cfg_asyncen
);
  logic [7:0] cfg_q;
  logic [9:0] res_q;
  logic       lock_q;

  wire mode10 = (cfg_q[3:2] == 2'b01);
  wire rd_hi  = bus_rd && (bus_addr == 2'd0);
  wire rd_lo  = bus_rd && (bus_addr == 2'd1);
  wire load   = conv_done && (!mode10 || (!lock_q && !rd_hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      res_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == 2'd2) cfg_q <= bus_wdata;
      if (load) res_q <= conv_data;
      if (!mode10 || rd_lo) lock_q <= 1'b0;
      else if (rd_hi) lock_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = mode10 ? {6'b0, res_q[9:8]} : 8'h00;
      2'd1:    bus_rdata = res_q[7:0];
      2'd2:    bus_rdata = cfg_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign cfg_lowpwr  = cfg_q[7];
  assign cfg_clkdiv  = cfg_q[6:5];
  assign cfg_clksel  = cfg_q[4];
  assign cfg_mode    = cfg_q[3:2];
  assign cfg_longsmp = cfg_q[1];
  assign cfg_asyncen = cfg_q[0];

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !lock_q && !rd_hi) |=> (res_q == $past(conv_data)));
  a_r2_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && mode10) |=> lock_q);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && mode10) |=> $stable(res_q));
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> !lock_q);
  a_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && mode10) |=> $stable(res_q));
  a_r5_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !mode10) |=> (res_q == $past(conv_data)));
  a_r5_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0 && !mode10) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/sim_adc_result_lock.sv
module sim_adc_result_lock;
  logic clk = 0, rst_n = 0;
  logic conv_done = 0, bus_rd = 0, bus_wr = 0;
  logic [9:0] conv_data = '0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic cfg_lowpwr, cfg_clksel, cfg_longsmp, cfg_asyncen;
  logic [1:0] cfg_clkdiv, cfg_mode;
  int checks = 0, failures = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  adc_result_lock u0 (.clk, .rst_n, .conv_done, .conv_data, .bus_addr, .bus_rd,
    .bus_wr, .bus_wdata, .bus_rdata, .cfg_lowpwr, .cfg_clkdiv, .cfg_clksel,
    .cfg_mode, .cfg_longsmp, .cfg_asyncen);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic conv(input logic [9:0] v);
    @(negedge clk); conv_data = v; conv_done = 1;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic rd_hi_conv(input logic [9:0] v, output logic [7:0] d);
    @(negedge clk); bus_addr = 0; bus_rd = 1; conv_data = v; conv_done = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0; conv_done = 0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    rd(2, rv); chk("R8 cfg", rv, 0);
    rd(1, rv); chk("R8 lo", rv, 0);
    rd(0, rv); chk("R8 hi", rv, 0);
    rd(3, rv); chk("R8 addr3", rv, 0);

    // R7 config sweep
    for (int c = 0; c < 256; c++) begin
      wr(2, c[7:0]);
      rd(2, rv); chk("R7 readback", rv, c);
      chk("R7 fields", {cfg_lowpwr, cfg_clkdiv, cfg_clksel, cfg_mode, cfg_longsmp, cfg_asyncen}, c);
    end

    // R6 R1 10-bit sweep
    wr(2, 8'h04);
    for (int v = 0; v < 1024; v++) begin
      conv(v[9:0]);
      rd(0, rv); chk("R6 hi", rv, v >> 8);
      rd(1, rv); chk("R6 lo", rv, v & 8'hff);
    end

    // R2 R3 lock ordering
    conv(10'h2a5);
    rd(0, rv); chk("R2 hi", rv, 2);
    conv(10'h15a);
    rd(0, rv); chk("R2 hi held", rv, 2);
    rd(1, rv); chk("R2 lo held", rv, 8'ha5);
    conv(10'h15a);
    rd(0, rv); chk("R3 hi new", rv, 1);
    rd(1, rv); chk("R3 lo new", rv, 8'h5a);

    // R4 same-cycle high read and conversion
    conv(10'h3c3);
    rd_hi_conv(10'h001, rv); chk("R4 read old", rv, 3);
    rd(1, rv); chk("R4 dropped", rv, 8'hc3);

    // R9 low read without lock, writes to result ignored
    rd(1, rv);
    conv(10'h0f0);
    rd(1, rv); chk("R9 lo no side effect", rv, 8'hf0);
    wr(0, 8'hff); wr(1, 8'h11);
    rd(0, rv); chk("R9 hi write ignored", rv, 0);
    rd(1, rv); chk("R9 lo write ignored", rv, 8'hf0);
    rd(2, rv); chk("R9 cfg untouched", rv, 8'h04);

    // R5 8-bit class modes
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      wr(2, 8'(m << 2));
      for (int v = 0; v < 256; v++) begin
        conv({2'b11, v[7:0]});
        rd(0, rv); chk("R5 hi zero", rv, 0);
        conv({2'b10, ~v[7:0]});
        rd(1, rv); chk("R5 no lock", rv, (~v) & 8'hff);
      end
      rd_hi_conv(10'h2ab, rv); chk("R5 same-cycle hi", rv, 0);
      rd(1, rv); chk("R5 same-cycle loaded", rv, 8'hab);
    end

    // R8 reset mid-run
    wr(2, 8'h04); conv(10'h3ff); rd(0, rv);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(1, rv); chk("R8 lo after reset", rv, 0);
    rd(2, rv); chk("R8 cfg after reset", rv, 0);
    wr(2, 8'h04); conv(10'h155);
    rd(1, rv); chk("R8 lock cleared", rv, 8'h55);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule